// File: doc/BRIEF.md
# RC Discharge-Time Auto-Calibrating Measurement Sequencer

This block measures a resistive sensor by timing how long a capacitor takes to discharge through it. It controls one capacitor-sense pin and four discharge pins, each through an output-enable and an output-value signal. A pad ring turns these into tri-state drives. For each measurement slot the block first charges the capacitor from the sense pin for a programmed number of clock cycles. It then releases the sense pin, pulls one or two discharge pins low, and counts clock cycles until the thresholded sense input reads 0.

One run produces three counts in single-sensor mode (sensor path, reference path, offset path) or four counts in bridge mode. Some bridge slots discharge through two pins in parallel. Software or downstream logic forms ratios of these counts, so gain and offset errors of the analog network cancel. The counter is cleared on the same edge that applies the discharge drive, so the start of each interval has no quantisation error. The end of the interval is quantised to one clock period.

A slot whose sense input never falls before a programmed timeout is marked as overflowed. The `charge_cycles` setting must be at least `SYNC_STAGES + 1`, so that the synchronised sense input is high again before each discharge begins.

Top module: `rcd_sequencer`

## Requirements
- R1: In every charge phase, `sense_oe`=1, `sense_out`=1 and `dis_oe`=0. The phase lasts exactly `charge_cycles` clock cycles, and one charge phase precedes every discharge phase.
- R2: In every discharge phase, `sense_oe`=0, `dis_out`=0, and `dis_oe` equals the slot's pin mask, where bit i is discharge pin i.
  - Single mode: slot0=4'b0001, slot1=4'b0010, slot2=4'b0100.
  - Bridge mode: slot0=4'b0001, slot1=4'b0010, slot2=4'b0110 (pins 1 and 2 in parallel), slot3=4'b1000.
- R3: The counter is cleared by the edge that applies the discharge drive. If `sense_in` is first sampled low at the j-th rising edge after that edge, the slot's count is j + SYNC_STAGES - 1.
- R4: If that value would exceed `timeout`, the slot's count is all ones and its bit in `slot_ovf` is 1. A value exactly equal to `timeout` is stored normally with its overflow bit 0.
- R5: A single-mode run has exactly 3 discharge phases and a bridge-mode run has exactly 4. `bridge_mode` is sampled only on the accepted `start` edge.
- R6: Slot i's count appears on `slot_count[i*CW +: CW]`. Accepting `start` clears all counts and overflow bits, so slot 3 reads 0 with its overflow bit 0 after a single-mode run.
- R7: `done` is high for exactly one cycle, in the cycle after the last slot's capture edge. In that same cycle `busy` is 0 and all results are valid.
- R8: `start` while `busy` is 1 is ignored: the running sequence, its mode and its results are unchanged.
- R9: After reset, `busy`, `done`, `sense_oe` and `dis_oe` are 0, and all counts and overflow bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| bridge_mode | input | 1 | 0: three slots; 1: four bridge slots (sampled at start) |
| charge_cycles | input | CW | Length of each charge phase in cycles |
| timeout | input | CW | Largest count accepted before a slot overflows |
| sense_in | input | 1 | Thresholded capacitor voltage (asynchronous) |
| sense_oe | output | 1 | Output enable of the sense pin |
| sense_out | output | 1 | Value driven on the sense pin |
| dis_oe | output | NUM_PINS | Output enables of the discharge pins |
| dis_out | output | NUM_PINS | Values driven on the discharge pins |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when all results of a run are valid |
| slot_count | output | NUM_SLOTS*CW | Captured count per slot, slot 0 in the low bits |
| slot_ovf | output | NUM_SLOTS | Overflow flag per slot |

## Verification
The bench drives `start` at a falling edge. The first charge cycle is visible at the next falling edge, and each discharge phase follows after exactly `charge_cycles` cycles. An RC model in the bench pulls `sense_in` low D falling edges into each discharge phase. The capture therefore happens SYNC_STAGES + 1 edges later, and the expected count is D + SYNC_STAGES, or all ones with the overflow bit set when that exceeds `timeout`. Results are read at the falling edge where `done` is first seen high, which is one cycle after the capture edge. The bench also checks that `done` is low one edge after that. Pin masks and charge lengths are recorded phase by phase at falling edges, so each slot is checked in the cycle its drive appears.

// File: rtl/rcd_pkg.sv
// Package: shared constants, state encoding and slot-to-pin mapping for the
// RC discharge-time sequencer. Assumes four discharge pins and four slots.
package rcd_pkg;

    parameter int NUM_PINS  = 4;
    parameter int NUM_SLOTS = 4;
    localparam int SLOT_W   = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_DISCH  = 2'd2
    } rcd_state_t;

    // Pin mask per slot and mode; bit i enables discharge pin i.
    function automatic logic [NUM_PINS-1:0] slot_mask(input logic bridge,
                                                      input logic [SLOT_W-1:0] slot);
        logic [NUM_PINS-1:0] m;
        m = '0;
        case (slot)
            2'd0: m[0] = 1'b1;
            2'd1: m[1] = 1'b1;
            2'd2: begin
                m[2] = 1'b1;
                m[1] = bridge;
            end
            default: m[3] = bridge;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rcd_sync.sv
// Module: rcd_sync
// Brings the asynchronous thresholded sense input into the clock domain
// through a chain of STAGES flip-flops. Assumes STAGES >= 1. The chain resets
// to 1 (capacitor treated as charged).
module rcd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single sampling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the sampled value through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rcd_timer.sv
// Module: rcd_timer
// Shared cycle counter used both for the charge length and for the
// discharge interval. Clear has priority over increment. Assumes the
// controller never asks it to pass its maximum value.
module rcd_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Count reference-clock edges; zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) value <= '0;
        else if (inc)      value <= value + 1'b1;
    end

    // Never wraps from all ones to zero by incrementing.
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (value != '1));

endmodule

// File: rtl/rcd_result_bank.sv
// Module: rcd_result_bank
// One count register and one overflow flag per measurement slot. All slots
// clear together when a run is accepted; one slot is written per capture.
module rcd_result_bank #(
    parameter int W      = 16,
    parameter int SLOTS  = 4,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [SW-1:0]    wr_slot,
    input  logic [W-1:0]     wr_val,
    input  logic             wr_ovf,
    output logic [SLOTS*W-1:0] counts,
    output logic [SLOTS-1:0] ovf
);

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            // Hold slot i's result until the next accepted run.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    counts[i*W +: W] <= '0;
                    ovf[i]           <= 1'b0;
                end else if (wr && (wr_slot == SW'(i))) begin
                    counts[i*W +: W] <= wr_val;
                    ovf[i]           <= wr_ovf;
                end
            end

            // An overflowed slot always reads saturated.
            assert_ovf_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ovf[i] |-> (counts[i*W +: W] == '1));
        end
    endgenerate

endmodule

// File: rtl/rcd_sequencer.sv
// Module: rcd_sequencer
// Runs charge / discharge-and-measure phases for three (single) or four
// (bridge) slots, capturing one count per slot from the cycle the discharge
// drive is applied until the synchronised sense input reads 0.
// Assumes charge_cycles >= SYNC_STAGES + 1 and that charge_cycles and
// timeout are held steady while busy.
module rcd_sequencer
    import rcd_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    bridge_mode,
    input  logic [CW-1:0]           charge_cycles,
    input  logic [CW-1:0]           timeout,
    input  logic                    sense_in,
    output logic                    sense_oe,
    output logic                    sense_out,
    output logic [NUM_PINS-1:0]     dis_oe,
    output logic [NUM_PINS-1:0]     dis_out,
    output logic                    busy,
    output logic                    done,
    output logic [NUM_SLOTS*CW-1:0] slot_count,
    output logic [NUM_SLOTS-1:0]    slot_ovf
);

    localparam logic [SLOT_W-1:0] LAST_SINGLE = SLOT_W'(NUM_SLOTS - 2);
    localparam logic [SLOT_W-1:0] LAST_BRIDGE = SLOT_W'(NUM_SLOTS - 1);

    rcd_state_t        st;
    logic [SLOT_W-1:0] slot;
    logic              bridge_q;
    logic              sense_sync;
    logic [CW-1:0]     tmr;
    logic [CW-1:0]     chg_limit;
    logic              sense_low;
    logic              finish;
    logic              charge_end;
    logic              accept;
    logic              tmr_clr;
    logic              tmr_inc;
    logic [SLOT_W-1:0] last_slot;

    rcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sense_in),
        .q     (sense_sync)
    );

    rcd_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .value (tmr)
    );

    rcd_result_bank #(.W(CW), .SLOTS(NUM_SLOTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .wr      (finish),
        .wr_slot (slot),
        .wr_val  (sense_low ? tmr : '1),
        .wr_ovf  (!sense_low),
        .counts  (slot_count),
        .ovf     (slot_ovf)
    );

    // Phase-end decisions and timer control.
    always_comb begin
        chg_limit  = (charge_cycles == '0) ? '0 : charge_cycles - 1'b1;
        sense_low  = !sense_sync;
        accept     = (st == ST_IDLE) && start;
        charge_end = (st == ST_CHARGE) && (tmr >= chg_limit);
        finish     = (st == ST_DISCH) && (sense_low || (tmr == timeout));
        tmr_clr    = accept || charge_end || finish;
        tmr_inc    = (st != ST_IDLE) && !tmr_clr;
        last_slot  = bridge_q ? LAST_BRIDGE : LAST_SINGLE;
    end

    // Sequence the phases and slots; emit the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            slot     <= '0;
            bridge_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st       <= ST_CHARGE;
                        slot     <= '0;
                        bridge_q <= bridge_mode;
                    end
                end
                ST_CHARGE: begin
                    if (charge_end) st <= ST_DISCH;
                end
                ST_DISCH: begin
                    if (finish) begin
                        if (slot == last_slot) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            slot <= slot + 1'b1;
                            st   <= ST_CHARGE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Pin drive decoded from the phase and slot.
    always_comb begin
        sense_oe  = (st == ST_CHARGE);
        sense_out = (st == ST_CHARGE);
        dis_oe    = (st == ST_DISCH) ? slot_mask(bridge_q, slot) : '0;
        dis_out   = '0;
        busy      = (st != ST_IDLE);
    end

    // Sense pin and discharge pins are never driven together.
    assert_excl_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sense_oe |-> (dis_oe == '0));

    // A discharge phase drives one or two pins low.
    assert_pin_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_oe != '0) |-> (($countones(dis_oe) <= 2) && (dis_out == '0)));

    // The discharge count never passes the timeout.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISCH) |-> (tmr <= timeout));

    // Completion is a single-cycle pulse while idle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // A start while busy does not restart the slot sequence.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !finish) |=> (slot == $past(slot)));

endmodule

// File: tb/tb_rcd_sequencer.sv
`timescale 1ns/1ps
// Bench: models the RC network (sense falls D cycles into each discharge),
// runs directed corners and seeded random runs, checks results by function.
module tb_rcd_sequencer;

    localparam int CW   = 16;
    localparam int SYNC = 2;
    localparam int NP   = 4;
    localparam int NS   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bridge_mode = 1'b0;
    logic [CW-1:0] charge_cycles = 16'd5;
    logic [CW-1:0] timeout = 16'd100;
    logic sense_in = 1'b1;
    logic sense_oe, sense_out, busy, done;
    logic [NP-1:0] dis_oe, dis_out;
    logic [NS*CW-1:0] slot_count;
    logic [NS-1:0] slot_ovf;

    int errors = 0;
    int checks = 0;
    int dly [NS];
    int obs_mask [NS];
    int obs_chg [NS];
    int seen = 0;
    int chg_len = 0;
    bit was_chg = 0;
    bit in_dis = 0;
    int dcnt = 0;

    always #2.5 clk = ~clk;

    rcd_sequencer #(.CW(CW), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bridge_mode(bridge_mode),
        .charge_cycles(charge_cycles), .timeout(timeout), .sense_in(sense_in),
        .sense_oe(sense_oe), .sense_out(sense_out), .dis_oe(dis_oe),
        .dis_out(dis_out), .busy(busy), .done(done),
        .slot_count(slot_count), .slot_ovf(slot_ovf)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mask(input bit br, input int s);
        case (s)
            0: return 1;
            1: return 2;
            2: return br ? 6 : 4;
            default: return br ? 8 : 0;
        endcase
    endfunction

    // RC model and phase monitor, evaluated at falling edges.
    always @(negedge clk) begin
        if (sense_oe) begin
            chg_len = was_chg ? chg_len + 1 : 1;
            was_chg = 1;
            sense_in = 1'b1;
            in_dis = 0;
            dcnt = 0;
        end else begin
            was_chg = 0;
            if (dis_oe != '0) begin
                if (!in_dis) begin
                    if (seen < NS) begin
                        obs_mask[seen] = int'(dis_oe);
                        obs_chg[seen] = chg_len;
                    end
                    seen++;
                    in_dis = 1;
                end
                if (seen >= 1 && seen <= NS && dcnt >= dly[seen-1]) sense_in = 1'b0;
                dcnt++;
            end
        end
    end

    task automatic run_case(input bit br, input int chg, input int tmo,
                            input int d0, input int d1, input int d2, input int d3,
                            input bit poke);
        int ns;
        int wait_n;
        dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
        @(negedge clk);
        seen = 0;
        bridge_mode = br;
        charge_cycles = CW'(chg);
        timeout = CW'(tmo);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            bridge_mode = ~br;
            @(negedge clk);
            start = 1'b0;
            bridge_mode = br;
        end
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done == 1'b1, "R7 done seen", done, 1);
        chk(busy == 1'b0, "R7 busy low with done", busy, 0);
        ns = br ? 4 : 3;
        // R5 slot count per mode (R8: poke must not change it)
        chk(seen == ns, "R5/R8 discharge phases", seen, ns);
        for (int i = 0; i < ns; i++) begin
            longint e;
            bit eo;
            e = dly[i] + SYNC;
            eo = (e > tmo);
            if (eo) e = 65535;
            chk(obs_mask[i] == exp_mask(br, i), "R2 pin mask", obs_mask[i], exp_mask(br, i));
            chk(obs_chg[i] == chg, "R1 charge length", obs_chg[i], chg);
            chk(slot_count[i*CW +: CW] == CW'(e), "R3/R4 slot count", slot_count[i*CW +: CW], e);
            chk(slot_ovf[i] == eo, "R4 overflow flag", slot_ovf[i], eo);
        end
        if (!br) begin
            chk(slot_count[3*CW +: CW] == '0, "R6 unused slot cleared", slot_count[3*CW +: CW], 0);
            chk(slot_ovf[3] == 1'b0, "R6 unused ovf cleared", slot_ovf[3], 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'h1c3a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(busy == 0 && done == 0, "R9 idle after reset", {busy, done}, 0);
        chk(sense_oe == 0 && dis_oe == '0, "R9 pins released", {sense_oe, dis_oe}, 0);
        chk(slot_count == '0 && slot_ovf == '0, "R9 results zero", slot_count, 0);

        run_case(0, 5, 100, 10, 20, 3, 0, 0);
        run_case(1, 8, 100, 0, 15, 30, 50, 0);
        // R4 boundary: 38+2 == timeout stored; 39+2 overflows; R6 slot3 cleared
        run_case(0, 4, 40, 38, 39, 0, 0, 0);
        // R8 start during run ignored
        run_case(0, 6, 200, 12, 7, 25, 0, 1);
        run_case(1, 3, 30, 100000, 5, 100000, 28, 0);

        for (int k = 0; k < 20; k++) begin
            int t;
            t = 5 + int'($urandom_range(0, 250));
            run_case(1'($urandom_range(0, 1)), 3 + int'($urandom_range(0, 17)), t,
                     int'($urandom_range(0, t + 4)), int'($urandom_range(0, t + 4)),
                     int'($urandom_range(0, t + 4)), int'($urandom_range(0, t + 4)), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule